// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

This block is a first-in, first-out buffer for 18-bit words. The write side and the read side each have their own clock. The two clocks may come from one source or run with no fixed relation to each other. Words are pushed on write-clock edges while the write enable is high. Words are taken on read-clock edges while the read enable is high. An output enable gates the data bus down to zero.

The block has two read timing behaviours, and a strap input picks one while reset is held. In the explicit-read behaviour, the output register changes only when a read is performed, and the first status output reports "empty". In the fall-through behaviour, the oldest word is moved to the output on its own, and the same status output reports "a valid word is presented". The second fixed status output works the same way: in the explicit-read behaviour it reports "full", and in the fall-through behaviour it reports "a write would be accepted".

A half-full output and two threshold outputs near empty and near full complete the status set. The offsets for the two threshold outputs are loaded through the write port. The load input is held high, and the write enable is pulsed once per offset.

Top module: `dual_mode_fifo`

## Requirements
- R1: Words accepted on rising `wclk` edges (`wen`=1, `ld`=0, not full) are delivered in the order they were written. The pointers cross between clock domains in Gray code, and each Gray register changes by at most one bit per edge.
- R2: In explicit-read mode, `full_ir` is 1 exactly when DEPTH words are stored. A write while full is ignored and overwrites nothing.
- R3: In explicit-read mode, a read (`ren`=1 on a rising `rclk` edge) while the FIFO is empty is ignored. `dout` and the read pointer stay unchanged.
- R4: In explicit-read mode, `dout` changes only on a read, and `empty_or` is 1 exactly when no word is stored. With both clocks from one source, a write into an empty FIFO clears `empty_or` after the second `rclk` edge that follows the write edge.
- R5: In fall-through mode, after a write into an empty FIFO, the word appears on `dout` with `empty_or`=1 after the third `rclk` edge that follows the write edge, with no read enable needed. A read while `empty_or`=1 consumes the word. On that same edge the next word appears, or `empty_or` drops. `dout` holds while `ren`=0.
- R6: In fall-through mode, `full_ir`=1 means a write would be accepted. The FIFO then holds DEPTH+1 words: DEPTH in memory and one presented on the output.
- R7: `half_full` is 1 when the write-side word count exceeds DEPTH/2.
- R8: `almost_empty` is 1 when the read-side count of words in memory is at most the near-empty offset. This count excludes a word already presented in fall-through mode. `almost_full` is 1 when the write-side count is at least DEPTH minus the near-full offset. Both offsets are 7 after reset.
- R9: While `ld`=1, each `wclk` cycle with `wen`=1 stores `din[log2(DEPTH)-1:0]` into the offsets in turn: near-empty first, then near-full, then near-empty again. The turn returns to near-empty whenever `ld`=0. These cycles write nothing into the FIFO.
- R10: `oe`=0 forces `dout` to all zeros. `oe`=1 shows the held output word.
- R11: `fwft_mode` (1 = fall-through) is sampled only while reset is held. `rst_n`=0 resets asynchronously, and each domain leaves reset two of its own clock edges after release. Reset clears both pointers and sets `dout`=0. It then sets `empty_or`=1 and `full_ir`=0 in explicit-read mode, or `empty_or`=0 and `full_ir`=1 in fall-through mode. It also sets `almost_empty`=1, `half_full`=0 and `almost_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwft_mode | input | 1 | Read timing strap, 1 = fall-through, sampled during reset |
| wen | input | 1 | Write enable |
| ld | input | 1 | Offset load select for write cycles |
| din | input | DATA_W | Write data; low log2(DEPTH) bits carry an offset during a load |
| ren | input | 1 | Read enable |
| oe | input | 1 | Output enable, 0 drives zeros |
| dout | output | DATA_W | Read data |
| empty_or | output | 1 | Empty (explicit-read) or output ready (fall-through) |
| full_ir | output | 1 | Full (explicit-read) or input ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |
| almost_empty | output | 1 | Read-side count at or below the near-empty offset |
| almost_full | output | 1 | Write-side count at or above DEPTH minus the near-full offset |

## Verification
A read pointer that runs past the write pointer shows up at once as stale or repeated words on `dout`. Such a pointer also makes `empty_or` fail to rise at the right count, and both faults appear within the same read burst. A bad synchronizer stage count or a wrong Gray conversion moves the fall-through arrival of the first word off its third edge, or the explicit-read empty release off its second edge. Both edges are sampled exactly. A mis-stepped offset selector or a wrongly stored offset moves the `almost_empty` or `almost_full` switching point by one or more words. This shows on the very write that crosses the programmed threshold.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Which offset register the next load cycle targets
  typedef enum logic {
    SEL_NEAR_EMPTY = 1'b0,
    SEL_NEAR_FULL  = 1'b1
  } ofs_sel_e;

  localparam int unsigned DEFAULT_OFFSET = 7;
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = stg_q[STAGES-1];
endmodule

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // Gray to binary: running XOR from the top bit down
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W-1; i >= 0; i--) begin
      acc      = acc ^ stg_q[STAGES-1][i];
      bin_o[i] = acc;
    end
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wen,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ofs_din,
  input  logic [PTR_W-1:0]  rd_bin_sync,
  output logic              mem_we,
  output logic [PTR_W-1:0]  wr_bin,
  output logic [PTR_W-1:0]  wr_gray,
  output logic              full_int,
  output logic [ADDR_W-1:0] near_empty_ofs,
  output logic              full_ir,
  output logic              half_full,
  output logic              almost_full
);
  logic [PTR_W-1:0]  wr_bin_q, wr_bin_d, wr_gray_q, wr_gray_d;
  logic [ADDR_W-1:0] ne_ofs_q, ne_ofs_d, nf_ofs_q, nf_ofs_d;
  ofs_sel_e          sel_q, sel_d;
  logic              fwft_q;
  logic [PTR_W-1:0]  level;
  logic              push;

  assign level    = wr_bin_q - rd_bin_sync;
  assign full_int = (level == PTR_W'(DEPTH));
  assign push     = wen & ~ld & ~full_int;

  always_comb begin
    wr_bin_d = wr_bin_q;
    if (push) wr_bin_d = wr_bin_q + 1'b1;
    wr_gray_d = wr_bin_d ^ (wr_bin_d >> 1);

    ne_ofs_d = ne_ofs_q;
    nf_ofs_d = nf_ofs_q;
    sel_d    = sel_q;
    if (!ld) begin
      sel_d = SEL_NEAR_EMPTY;
    end else if (wen) begin
      if (sel_q == SEL_NEAR_EMPTY) ne_ofs_d = ofs_din;
      else                         nf_ofs_d = ofs_din;
      sel_d = (sel_q == SEL_NEAR_EMPTY) ? SEL_NEAR_FULL : SEL_NEAR_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
      ne_ofs_q  <= ADDR_W'(DEFAULT_OFFSET);
      nf_ofs_q  <= ADDR_W'(DEFAULT_OFFSET);
      sel_q     <= SEL_NEAR_EMPTY;
    end else begin
      wr_bin_q  <= wr_bin_d;
      wr_gray_q <= wr_gray_d;
      ne_ofs_q  <= ne_ofs_d;
      nf_ofs_q  <= nf_ofs_d;
      sel_q     <= sel_d;
    end
  end

  // Strap capture: loads only while the domain is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n) fwft_q <= fwft_mode;
  end

  assign mem_we         = push;
  assign wr_bin         = wr_bin_q;
  assign wr_gray        = wr_gray_q;
  assign near_empty_ofs = ne_ofs_q;
  assign full_ir        = fwft_q ? ~full_int : full_int;
  assign half_full      = (level > PTR_W'(DEPTH / 2));
  assign almost_full    = (level >= (PTR_W'(DEPTH) - {1'b0, nf_ofs_q}));
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              ren,
  input  logic [PTR_W-1:0]  wr_bin_sync,
  input  logic [ADDR_W-1:0] near_empty_ofs,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PTR_W-1:0]  rd_bin,
  output logic [PTR_W-1:0]  rd_gray,
  output logic              empty_int,
  output logic              fwft_o,
  output logic [DATA_W-1:0] dout_q,
  output logic              empty_or,
  output logic              almost_empty
);
  logic [PTR_W-1:0]  rd_bin_q, rd_bin_d, rd_gray_q, rd_gray_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              fwft_q;
  logic              pop;
  logic [PTR_W-1:0]  level;

  assign level     = wr_bin_sync - rd_bin_q;
  assign empty_int = (level == '0);

  always_comb begin
    pop     = 1'b0;
    data_d  = data_q;
    valid_d = valid_q;
    if (fwft_q) begin
      if (!valid_q || ren) begin
        if (!empty_int) begin
          pop     = 1'b1;
          data_d  = mem_rdata;
          valid_d = 1'b1;
        end else begin
          valid_d = 1'b0;
        end
      end
    end else if (ren && !empty_int) begin
      pop    = 1'b1;
      data_d = mem_rdata;
    end
    rd_bin_d = rd_bin_q;
    if (pop) rd_bin_d = rd_bin_q + 1'b1;
    rd_gray_d = rd_bin_d ^ (rd_bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      data_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      rd_bin_q  <= rd_bin_d;
      rd_gray_q <= rd_gray_d;
      data_q    <= data_d;
      valid_q   <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fwft_q <= fwft_mode;
  end

  assign rd_bin       = rd_bin_q;
  assign rd_gray      = rd_gray_q;
  assign fwft_o       = fwft_q;
  assign dout_q       = data_q;
  assign empty_or     = fwft_q ? valid_q : empty_int;
  assign almost_empty = (level <= {1'b0, near_empty_ofs});
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wen,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  input  logic              ren,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              empty_or,
  output logic              full_ir,
  output logic              half_full,
  output logic              almost_empty,
  output logic              almost_full
);
  localparam int ADDR_W      = $clog2(DEPTH);
  localparam int PTR_W       = ADDR_W + 1;
  localparam int SYNC_STAGES = 2;

  logic              wrst_n, rrst_n;
  logic              mem_we;
  logic [PTR_W-1:0]  wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PTR_W-1:0]  wr_bin_rs, rd_bin_ws;
  logic              full_int, empty_int, fwft_rd;
  logic [ADDR_W-1:0] near_empty_ofs;
  logic [DATA_W-1:0] mem_rdata, dout_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .arst_n(rst_n), .rst_n_o(wrst_n)
  );
  fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rclk), .arst_n(rst_n), .rst_n_o(rrst_n)
  );

  fifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk            (wclk),
    .rst_n          (wrst_n),
    .fwft_mode      (fwft_mode),
    .wen            (wen),
    .ld             (ld),
    .ofs_din        (din[ADDR_W-1:0]),
    .rd_bin_sync    (rd_bin_ws),
    .mem_we         (mem_we),
    .wr_bin         (wr_bin),
    .wr_gray        (wr_gray),
    .full_int       (full_int),
    .near_empty_ofs (near_empty_ofs),
    .full_ir        (full_ir),
    .half_full      (half_full),
    .almost_full    (almost_full)
  );

  fifo_ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_i(wr_gray), .bin_o(wr_bin_rs)
  );
  fifo_ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_i(rd_gray), .bin_o(rd_bin_ws)
  );

  fifo_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk            (rclk),
    .rst_n          (rrst_n),
    .fwft_mode      (fwft_mode),
    .ren            (ren),
    .wr_bin_sync    (wr_bin_rs),
    .near_empty_ofs (near_empty_ofs),
    .mem_rdata      (mem_rdata),
    .rd_bin         (rd_bin),
    .rd_gray        (rd_gray),
    .empty_int      (empty_int),
    .fwft_o         (fwft_rd),
    .dout_q         (dout_q),
    .empty_or       (empty_or),
    .almost_empty   (almost_empty)
  );

  // Storage array, written in the write domain
  always_ff @(posedge wclk) begin
    if (mem_we) mem_q[wr_bin[ADDR_W-1:0]] <= din;
  end

  assign mem_rdata = mem_q[rd_bin[ADDR_W-1:0]];
  assign dout      = oe ? dout_q : '0;
endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int DATA_W = 18,
  parameter int PTR_W  = 9
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrst_n,
  input logic              rrst_n,
  input logic              ren,
  input logic [PTR_W-1:0]  wr_bin,
  input logic [PTR_W-1:0]  rd_bin,
  input logic [PTR_W-1:0]  wr_gray,
  input logic [PTR_W-1:0]  rd_gray,
  input logic              full_int,
  input logic              empty_int,
  input logic              fwft_rd,
  input logic [DATA_W-1:0] dout_q,
  input logic              empty_or,
  input logic              half_full,
  input logic              almost_full
);
  // R2: a full FIFO never advances its write pointer
  a_r2_full_holds_wptr: assert property (@(posedge wclk) disable iff (!wrst_n)
    full_int |=> (wr_bin == $past(wr_bin)));

  // R3: an empty FIFO never advances its read pointer
  a_r3_empty_holds_rptr: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty_int |=> (rd_bin == $past(rd_bin)));

  // R4: explicit-read output register moves only on an accepted read
  a_r4_std_dout_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!fwft_rd && !(ren && !empty_int)) |=> $stable(dout_q));

  // R5: a presented word stays presented until it is consumed
  a_r5_presented_word_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
    (fwft_rd && empty_or && !ren) |=> (empty_or && $stable(dout_q)));

  // R1: Gray pointers move by at most one bit per edge
  a_r1_wgray_one_bit: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(wr_gray ^ $past(wr_gray)));
  a_r1_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rrst_n)
    $onehot0(rd_gray ^ $past(rd_gray)));

  // R7 and R8: a full write side also reports half full and almost full
  a_r8_full_sets_upper_flags: assert property (@(posedge wclk) disable iff (!wrst_n)
    full_int |-> (half_full && almost_full));
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .wclk        (wclk),
  .rclk        (rclk),
  .wrst_n      (wrst_n),
  .rrst_n      (rrst_n),
  .ren         (ren),
  .wr_bin      (wr_bin),
  .rd_bin      (rd_bin),
  .wr_gray     (wr_gray),
  .rd_gray     (rd_gray),
  .full_int    (full_int),
  .empty_int   (empty_int),
  .fwft_rd     (fwft_rd),
  .dout_q      (dout_q),
  .empty_or    (empty_or),
  .half_full   (half_full),
  .almost_full (almost_full)
);

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 32;

  typedef struct packed {
    int   nw;
    int   nr;
    logic e;
    logic f;
    logic ae;
    logic hf;
    logic af;
  } vec_t;

  // writes, reads, then expected empty/full/almost-empty/half/almost-full
  localparam vec_t VECS [11] = '{
    '{5,  0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},   // 5 words
    '{3,  0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},   // 8
    '{9,  0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},   // 17
    '{8,  0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},   // 25
    '{10, 0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},   // 32, three refused
    '{0,  1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},   // 31
    '{0,  24, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},   // 7
    '{0,  7,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // 0
    '{0,  3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // reads on empty
    '{3,  2,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},   // 1
    '{0,  1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0}    // 0
  };

  logic          clk, rst_n, fwft_mode, wen, ld, ren, oe;
  logic [DW-1:0] din, dout;
  logic          empty_or, full_ir, half_full, almost_empty, almost_full;

  dual_mode_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wen(wen), .ld(ld), .din(din), .ren(ren), .oe(oe), .dout(dout),
    .empty_or(empty_or), .full_ir(full_ir), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int            n_checks, n_fail, cap;
  bit            done;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] last_rd, next_word;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) tick();
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      wen = 1'b1;
      din = next_word;
      tick();
      if (model_q.size() < cap) model_q.push_back(next_word);
      next_word = next_word + 1'b1;
    end
    wen = 1'b0;
  endtask

  task automatic read_std(input int n);
    for (int i = 0; i < n; i++) begin
      ren = 1'b1;
      tick();
      if (model_q.size() > 0) begin
        last_rd = model_q.pop_front();
        check("R1 read order", dout, last_rd);
      end else begin
        check("R3 read on empty", dout, last_rd);
      end
    end
    ren = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; fwft_mode = mode;
    wen = 1'b0; ren = 1'b0; ld = 1'b0; oe = 1'b1; din = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    model_q.delete();
    cap     = mode ? DEPTH + 1 : DEPTH;
    last_rd = '0;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    next_word = 18'h1000;

    // R11: reset state, explicit-read mode
    do_reset(1'b0);
    check("R11 dout", dout, 0);
    check("R11 empty", empty_or, 1);
    check("R11 full", full_ir, 0);
    check("R11 almost_empty", almost_empty, 1);
    check("R11 half_full", half_full, 0);
    check("R11 almost_full", almost_full, 0);

    // Vector table
    foreach (VECS[k]) begin
      write_n(VECS[k].nw);
      settle();
      read_std(VECS[k].nr);
      settle();
      check("R4 empty flag", empty_or, VECS[k].e);
      check("R2 full flag", full_ir, VECS[k].f);
      check("R8 almost_empty", almost_empty, VECS[k].ae);
      check("R7 half_full", half_full, VECS[k].hf);
      check("R8 almost_full", almost_full, VECS[k].af);
    end

    // R4: empty release timing and no unrequested output change
    wen = 1'b1; din = next_word; tick(); wen = 1'b0;
    model_q.push_back(next_word); next_word = next_word + 1'b1;
    check("R4 empty after write edge", empty_or, 1);
    tick();
    check("R4 empty after 1st edge", empty_or, 1);
    tick();
    check("R4 empty after 2nd edge", empty_or, 0);
    check("R4 dout without read", dout, last_rd);
    read_std(1);
    check("R4 empty after last read", empty_or, 1);

    // R10: output enable
    oe = 1'b0; #1;
    check("R10 oe low", dout, 0);
    oe = 1'b1; #1;
    check("R10 oe high", dout, last_rd);

    // R9: offset load sequence (near-empty 3, near-full 20, near-empty 5)
    ld = 1'b1; wen = 1'b1;
    din = 18'd3;  tick();
    din = 18'd20; tick();
    din = 18'd5;  tick();
    ld = 1'b0; wen = 1'b0;
    settle();
    check("R9 load writes no data", empty_or, 1);
    write_n(5); settle();
    check("R9 near-empty offset 5 at 5", almost_empty, 1);
    write_n(1); settle();
    check("R8 near-empty offset 5 at 6", almost_empty, 0);
    write_n(5); settle();
    check("R9 near-full offset 20 at 11", almost_full, 0);
    write_n(1); settle();
    check("R9 near-full offset 20 at 12", almost_full, 1);
    read_std(12); settle();
    check("R1 drained", empty_or, 1);

    // R11: reset into fall-through mode
    do_reset(1'b1);
    check("R11 fwft ready low", empty_or, 0);
    check("R11 fwft input ready", full_ir, 1);
    check("R11 fwft dout", dout, 0);
    check("R11 fwft almost_empty", almost_empty, 1);

    // R5: first word arrives after the third edge
    wen = 1'b1; din = next_word; tick(); wen = 1'b0;
    model_q.push_back(next_word); next_word = next_word + 1'b1;
    check("R5 not ready at write edge", empty_or, 0);
    tick();
    check("R5 not ready after 1st edge", empty_or, 0);
    tick();
    check("R5 not ready after 2nd edge", empty_or, 0);
    tick();
    check("R5 ready after 3rd edge", empty_or, 1);
    check("R5 head word", dout, model_q[0]);
    tick(); tick();
    check("R5 word held without read", dout, model_q[0]);
    check("R5 ready held without read", empty_or, 1);
    ren = 1'b1; tick(); ren = 1'b0;
    void'(model_q.pop_front());
    check("R5 consumed last word", empty_or, 0);

    // R6: capacity DEPTH+1 and input-ready meaning
    write_n(DEPTH + 8);
    settle();
    check("R6 input ready low when full", full_ir, 0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      check("R5 ready during drain", empty_or, 1);
      check("R6 drain order", dout, model_q[0]);
      ren = 1'b1; tick(); ren = 1'b0;
      void'(model_q.pop_front());
    end
    check("R5 not ready after drain", empty_or, 0);
    settle();
    check("R6 input ready after drain", full_ir, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule